// File: doc/BRIEF.md
# Rewirable Filter and Transform Datapath

This block is a small arithmetic fabric that computes one of three signal kernels on a stream of 16-bit signed samples. The fabric has a fixed pool of operators: four multipliers, an adder tree with three adders, one subtractor and two arithmetic right-shift scalers. The same operators serve every kernel. A 2-bit kernel code is decoded into the select lines of an operand routing matrix. The matrix decides which delayed sample or feedback value reaches each multiplier, and whether the upper adder pair joins the tree. Changing the kernel changes only those selects. The operators themselves stay the same.

The supported kernels are:
- a 4-tap FIR;
- a first-order recursive (IIR) section with 16-bit feedback;
- a single Haar wavelet analysis stage, which yields an approximation and a detail value for each pair of samples.

Coefficients and per-kernel shift amounts are parameters. Each accepted sample produces its result one clock later.

A kernel change is requested with a load strobe. It is applied in the first cycle in which no sample is presented. That cycle flushes every history register, so the new kernel starts from a clean state.

Top module: `rdf_fabric`

## Requirements
- R1: After reset the kernel is FIR (code 00), `res_valid` is low, and every delay, feedback and pairing register is zero.
- R2: In FIR mode (code 00), every accepted sample x[n] gives `res_valid` high on the next cycle. `res_main` = bits [15:0] of ((C0·x[n] + C1·x[n-1] + C2·x[n-2] + C3·x[n-3]) >>> FIR_SHIFT), computed with full precision and an arithmetic shift. `res_aux` = 0.
- R3: In IIR mode (code 01), every accepted sample gives `res_main` = bits [15:0] of ((A·x[n] + B·y[n-1]) >>> IIR_SHIFT) one cycle later. Here y[n-1] is the previous 16-bit `res_main` of this mode, and `res_aux` = 0.
- R4: In Haar mode (code 10), samples form pairs (e, o). The first sample of a pair gives no output. The second gives `res_main` = bits [15:0] of ((H·e + H·o) >>> HAAR_SHIFT) and `res_aux` = bits [15:0] of ((H·e − H·o) >>> HAAR_SHIFT).
- R5: Code 11 halts the fabric. While it is active, samples are dropped, history is unchanged and `res_valid` stays low.
- R6: A load in a cycle with `smp_valid` low switches the kernel at that clock edge. A load in a cycle with `smp_valid` high is held pending: samples continue in the old kernel, and the switch happens in the first later cycle with `smp_valid` low. `res_valid` is low after the switch cycle.
- R7: Every switch clears the delay line, the IIR feedback and the Haar pair phase, even when the new code equals the old one.
- R8: When several loads arrive before the switch happens, only the most recent code is applied.
- R9: `res_valid` rises only in the cycle after an accepted sample that completes a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Strobe to request a kernel change |
| cfg_code | input | 2 | Kernel code: 00 FIR, 01 IIR, 10 Haar, 11 halt |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | 16 | Signed input sample |
| res_valid | output | 1 | Result present |
| res_main | output | 16 | FIR/IIR output or Haar approximation |
| res_aux | output | 16 | Haar detail, zero in other kernels |

## Verification
The FIR is driven in three ways, each exposing a different class of fault:
- a lone full-scale impulse, which shows each tap coefficient separately and in its proper position;
- alternating full-scale extremes, which stress sign extension and wrap of the 16-bit result;
- a long pseudo-random sweep, which checks all taps together.

The IIR receives a constant step, whose settling curve exposes a wrong feedback path or shift, followed by the same sweep. The Haar stage receives the sweep, so that pairing order and the sign of the difference are checked.

Switches are placed in mid-stream, requested while samples are flowing, and repeated to the same kernel. This separates a correct deferral and flush from stale history and from a switch that happens too early.

// File: rtl/rdf_pkg.sv
package rdf_pkg;
    localparam int SMP_W  = 16;
    localparam int PROD_W = 2 * SMP_W;
    localparam int ACC_W  = PROD_W + 2;
    localparam int N_MUL  = 4;
    localparam int SH_W   = 6;
    localparam int SRC_W  = 3;

    typedef enum logic [1:0] {
        K_FIR  = 2'b00,
        K_IIR  = 2'b01,
        K_HAAR = 2'b10,
        K_HALT = 2'b11
    } kern_e;

    localparam logic [SRC_W-1:0] SRC_CUR = 3'd0;
    localparam logic [SRC_W-1:0] SRC_D1  = 3'd1;
    localparam logic [SRC_W-1:0] SRC_D2  = 3'd2;
    localparam logic [SRC_W-1:0] SRC_D3  = 3'd3;
    localparam logic [SRC_W-1:0] SRC_FB  = 3'd4;
    localparam logic [SRC_W-1:0] SRC_NIL = 3'd5;

    typedef struct packed {
        logic [N_MUL-1:0][SRC_W-1:0] opnd_sel;
        logic [N_MUL-1:0][SMP_W-1:0] coef;
        logic                        tree_en;
        logic [SH_W-1:0]             sh_main;
        logic [SH_W-1:0]             sh_aux;
    } route_t;

    typedef struct packed {
        kern_e            kern;
        logic             pend;
        logic [1:0]       pend_code;
        logic [SMP_W-1:0] d1;
        logic [SMP_W-1:0] d2;
        logic [SMP_W-1:0] d3;
        logic [SMP_W-1:0] fb;
        logic             phase;
        logic             ov;
        logic [SMP_W-1:0] om;
        logic [SMP_W-1:0] oa;
    } fab_st_t;
endpackage

// File: rtl/rdf_cfg_decoder.sv
module rdf_cfg_decoder
    import rdf_pkg::*;
#(
    parameter logic signed [SMP_W-1:0] FIR_C0     = 16'sd1024,
    parameter logic signed [SMP_W-1:0] FIR_C1     = -16'sd2048,
    parameter logic signed [SMP_W-1:0] FIR_C2     = 16'sd3000,
    parameter logic signed [SMP_W-1:0] FIR_C3     = -16'sd700,
    parameter int                      FIR_SHIFT  = 4,
    parameter logic signed [SMP_W-1:0] IIR_A      = 16'sd16384,
    parameter logic signed [SMP_W-1:0] IIR_B      = 16'sd24576,
    parameter int                      IIR_SHIFT  = 15,
    parameter logic signed [SMP_W-1:0] HAAR_H     = 16'sd181,
    parameter int                      HAAR_SHIFT = 8
) (
    input  kern_e  kern_i,
    output route_t route_o
);
    always_comb begin
        route_o = '0;
        for (int i = 0; i < N_MUL; i++) begin
            route_o.opnd_sel[i] = SRC_NIL;
        end
        unique case (kern_i)
            K_FIR: begin
                route_o.opnd_sel[0] = SRC_CUR;
                route_o.opnd_sel[1] = SRC_D1;
                route_o.opnd_sel[2] = SRC_D2;
                route_o.opnd_sel[3] = SRC_D3;
                route_o.coef[0]     = FIR_C0;
                route_o.coef[1]     = FIR_C1;
                route_o.coef[2]     = FIR_C2;
                route_o.coef[3]     = FIR_C3;
                route_o.tree_en     = 1'b1;
                route_o.sh_main     = SH_W'(FIR_SHIFT);
            end
            K_IIR: begin
                route_o.opnd_sel[0] = SRC_CUR;
                route_o.opnd_sel[1] = SRC_FB;
                route_o.coef[0]     = IIR_A;
                route_o.coef[1]     = IIR_B;
                route_o.sh_main     = SH_W'(IIR_SHIFT);
            end
            K_HAAR: begin
                // Earlier sample of the pair on lane 0, so that the difference is e - o
                route_o.opnd_sel[0] = SRC_D1;
                route_o.opnd_sel[1] = SRC_CUR;
                route_o.coef[0]     = HAAR_H;
                route_o.coef[1]     = HAAR_H;
                route_o.sh_main     = SH_W'(HAAR_SHIFT);
                route_o.sh_aux      = SH_W'(HAAR_SHIFT);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rdf_route_matrix.sv
module rdf_route_matrix
    import rdf_pkg::*;
(
    input  logic [N_MUL-1:0][SRC_W-1:0] sel_i,
    input  logic [SMP_W-1:0]            cur_i,
    input  logic [SMP_W-1:0]            d1_i,
    input  logic [SMP_W-1:0]            d2_i,
    input  logic [SMP_W-1:0]            d3_i,
    input  logic [SMP_W-1:0]            fb_i,
    output logic [N_MUL-1:0][SMP_W-1:0] opnd_o
);
    for (genvar g = 0; g < N_MUL; g++) begin : g_lane
        always_comb begin
            case (sel_i[g])
                SRC_CUR: opnd_o[g] = cur_i;
                SRC_D1:  opnd_o[g] = d1_i;
                SRC_D2:  opnd_o[g] = d2_i;
                SRC_D3:  opnd_o[g] = d3_i;
                SRC_FB:  opnd_o[g] = fb_i;
                default: opnd_o[g] = '0;
            endcase
        end
    end
endmodule

// File: rtl/rdf_unit_pool.sv
module rdf_unit_pool
    import rdf_pkg::*;
(
    input  logic [N_MUL-1:0][SMP_W-1:0] opnd_i,
    input  logic [N_MUL-1:0][SMP_W-1:0] coef_i,
    input  logic                        tree_en_i,
    input  logic [SH_W-1:0]             sh_main_i,
    input  logic [SH_W-1:0]             sh_aux_i,
    output logic [SMP_W-1:0]            main_o,
    output logic [SMP_W-1:0]            aux_o
);
    logic signed [PROD_W-1:0] prod [N_MUL];
    logic signed [ACC_W-1:0]  sum_lo, sum_hi, tree, diff;

    for (genvar g = 0; g < N_MUL; g++) begin : g_mul
        assign prod[g] = PROD_W'($signed(opnd_i[g])) * PROD_W'($signed(coef_i[g]));
    end

    assign sum_lo = ACC_W'(prod[0]) + ACC_W'(prod[1]);
    assign sum_hi = ACC_W'(prod[2]) + ACC_W'(prod[3]);
    assign tree   = sum_lo + (tree_en_i ? sum_hi : '0);
    assign diff   = ACC_W'(prod[0]) - ACC_W'(prod[1]);

    assign main_o = SMP_W'(tree >>> sh_main_i);
    assign aux_o  = SMP_W'(diff >>> sh_aux_i);
endmodule

// File: rtl/rdf_fabric.sv
module rdf_fabric
    import rdf_pkg::*;
#(
    parameter logic signed [SMP_W-1:0] FIR_C0     = 16'sd1024,
    parameter logic signed [SMP_W-1:0] FIR_C1     = -16'sd2048,
    parameter logic signed [SMP_W-1:0] FIR_C2     = 16'sd3000,
    parameter logic signed [SMP_W-1:0] FIR_C3     = -16'sd700,
    parameter int                      FIR_SHIFT  = 4,
    parameter logic signed [SMP_W-1:0] IIR_A      = 16'sd16384,
    parameter logic signed [SMP_W-1:0] IIR_B      = 16'sd24576,
    parameter int                      IIR_SHIFT  = 15,
    parameter logic signed [SMP_W-1:0] HAAR_H     = 16'sd181,
    parameter int                      HAAR_SHIFT = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_load,
    input  logic [1:0]  cfg_code,
    input  logic        smp_valid,
    input  logic [15:0] smp_data,
    output logic        res_valid,
    output logic [15:0] res_main,
    output logic [15:0] res_aux
);
    fab_st_t s_q, s_d;
    route_t  route;
    logic [N_MUL-1:0][SMP_W-1:0] opnd;
    logic [SMP_W-1:0] pool_main, pool_aux;

    rdf_cfg_decoder #(
        .FIR_C0(FIR_C0), .FIR_C1(FIR_C1), .FIR_C2(FIR_C2), .FIR_C3(FIR_C3),
        .FIR_SHIFT(FIR_SHIFT), .IIR_A(IIR_A), .IIR_B(IIR_B), .IIR_SHIFT(IIR_SHIFT),
        .HAAR_H(HAAR_H), .HAAR_SHIFT(HAAR_SHIFT)
    ) u_dec (
        .kern_i (s_q.kern),
        .route_o(route)
    );

    rdf_route_matrix u_xbar (
        .sel_i (route.opnd_sel),
        .cur_i (smp_data),
        .d1_i  (s_q.d1),
        .d2_i  (s_q.d2),
        .d3_i  (s_q.d3),
        .fb_i  (s_q.fb),
        .opnd_o(opnd)
    );

    rdf_unit_pool u_pool (
        .opnd_i   (opnd),
        .coef_i   (route.coef),
        .tree_en_i(route.tree_en),
        .sh_main_i(route.sh_main),
        .sh_aux_i (route.sh_aux),
        .main_o   (pool_main),
        .aux_o    (pool_aux)
    );

    logic       take, want;
    logic [1:0] next_code;

    always_comb begin
        s_d       = s_q;
        s_d.ov    = 1'b0;
        take      = smp_valid && (s_q.kern != K_HALT);
        want      = cfg_load || s_q.pend;
        next_code = cfg_load ? cfg_code : s_q.pend_code;

        if (take) begin
            s_d.d1 = smp_data;
            s_d.d2 = s_q.d1;
            s_d.d3 = s_q.d2;
            case (s_q.kern)
                K_FIR: begin
                    s_d.ov = 1'b1;
                    s_d.om = pool_main;
                    s_d.oa = '0;
                end
                K_IIR: begin
                    s_d.ov = 1'b1;
                    s_d.om = pool_main;
                    s_d.oa = '0;
                    s_d.fb = pool_main;
                end
                K_HAAR: begin
                    s_d.phase = ~s_q.phase;
                    if (s_q.phase) begin
                        s_d.ov = 1'b1;
                        s_d.om = pool_main;
                        s_d.oa = pool_aux;
                    end
                end
                default: ;
            endcase
        end

        if (want) begin
            if (!smp_valid) begin
                s_d.kern  = kern_e'(next_code);
                s_d.pend  = 1'b0;
                s_d.d1    = '0;
                s_d.d2    = '0;
                s_d.d3    = '0;
                s_d.fb    = '0;
                s_d.phase = 1'b0;
                s_d.ov    = 1'b0;
            end else begin
                s_d.pend      = 1'b1;
                s_d.pend_code = next_code;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign res_valid = s_q.ov;
    assign res_main  = s_q.om;
    assign res_aux   = s_q.oa;

    // R9: no result without a sample in the cycle before
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !res_valid);

    // R2: each FIR sample is answered on the next cycle
    a_r2_fir_each: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && s_q.kern == K_FIR) |=> res_valid);

    // R4: the first sample of a pair is silent
    a_r4_pair_first: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && s_q.kern == K_HAAR && !s_q.phase) |=> !res_valid);

    // R5: the halt code never produces results
    a_r5_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.kern == K_HALT) |=> !res_valid);

    // R6: an idle-cycle load switches at once
    a_r6_switch_now: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && !smp_valid) |=> (!res_valid && s_q.kern == kern_e'($past(cfg_code))));

    // R6: without a request the kernel holds
    a_r6_kern_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_load && !s_q.pend) |=> $stable(s_q.kern));

    // R7: a switch leaves clean history
    a_r7_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && !smp_valid) |=> (s_q.d1 == '0 && s_q.d3 == '0 && s_q.fb == '0 && !s_q.phase));
endmodule

// File: tb/rdf_fabric_test.sv
module rdf_fabric_test;
    localparam longint C0 = 1024, C1 = -2048, C2 = 3000, C3 = -700;
    localparam int     FS = 4;
    localparam longint IA = 16384, IB = 24576;
    localparam int     IS = 15;
    localparam longint HH = 181;
    localparam int     HS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [1:0]  cfg_code = 2'b00;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        res_valid;
    logic [15:0] res_main, res_aux;

    int n_run = 0;
    int n_bad = 0;

    // reference model state
    logic [1:0]  m_kern = 2'b00;
    logic [15:0] m_d1 = '0, m_d2 = '0, m_d3 = '0, m_fb = '0;
    logic        m_ph = 1'b0;
    logic        m_pend = 1'b0;
    logic [1:0]  m_code = 2'b00;

    rdf_fabric uut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_code(cfg_code),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .res_valid(res_valid), .res_main(res_main), .res_aux(res_aux)
    );

    always #2 clk = ~clk;

    function automatic longint sx(input logic [15:0] v);
        return longint'($signed(v));
    endfunction

    task automatic check(input string req, input logic ev, input logic [15:0] em, input logic [15:0] ea);
        n_run++;
        if (res_valid !== ev || (ev && (res_main !== em || res_aux !== ea))) begin
            n_bad++;
            $display("FAIL %s: valid/main/aux got %b/%0d/%0d expected %b/%0d/%0d",
                     req, res_valid, $signed(res_main), $signed(res_aux), ev, $signed(em), $signed(ea));
        end
    endtask

    task automatic m_flush();
        m_d1 = '0; m_d2 = '0; m_d3 = '0; m_fb = '0; m_ph = 1'b0;
    endtask

    task automatic push(input logic [15:0] x, input logic ld, input logic [1:0] code, input string req);
        logic        ev;
        logic [15:0] em, ea;
        longint      acc, dif;
        ev = 1'b0; em = '0; ea = '0;
        @(negedge clk);
        smp_valid = 1'b1; smp_data = x; cfg_load = ld; cfg_code = code;
        case (m_kern)
            2'b00: begin
                acc = C0 * sx(x) + C1 * sx(m_d1) + C2 * sx(m_d2) + C3 * sx(m_d3);
                acc = acc >>> FS;
                ev = 1'b1; em = acc[15:0];
            end
            2'b01: begin
                acc = (IA * sx(x) + IB * sx(m_fb)) >>> IS;
                ev = 1'b1; em = acc[15:0]; m_fb = acc[15:0];
            end
            2'b10: begin
                if (m_ph) begin
                    acc = (HH * sx(m_d1) + HH * sx(x)) >>> HS;
                    dif = (HH * sx(m_d1) - HH * sx(x)) >>> HS;
                    ev = 1'b1; em = acc[15:0]; ea = dif[15:0];
                end
                m_ph = ~m_ph;
            end
            default: ;
        endcase
        if (m_kern != 2'b11) begin
            m_d3 = m_d2; m_d2 = m_d1; m_d1 = x;
        end
        if (ld) begin
            m_pend = 1'b1; m_code = code;
        end
        @(posedge clk); #1;
        check(req, ev, em, ea);
    endtask

    task automatic idle(input logic ld, input logic [1:0] code, input string req);
        @(negedge clk);
        smp_valid = 1'b0; cfg_load = ld; cfg_code = code;
        if (ld) begin
            m_pend = 1'b1; m_code = code;
        end
        if (m_pend) begin
            m_kern = m_code; m_pend = 1'b0; m_flush();
        end
        @(posedge clk); #1;
        check(req, 1'b0, '0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset valid low", 1'b0, '0, '0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 idle after reset", 1'b0, '0, '0);

        // R1/R2: FIR by default, clean history: impulse shows each tap
        push(16'sd32767, 0, 0, "R1 R2 impulse");
        for (int i = 0; i < 4; i++) push('0, 0, 0, "R2 impulse tail");
        for (int i = 0; i < 8; i++) push((i % 2) ? 16'h8000 : 16'h7fff, 0, 0, "R2 extremes");
        for (int i = 0; i < 400; i++) push(16'(i * 7919 + 13), 0, 0, "R2 sweep");

        // R7: reload the same kernel, history cleared
        idle(1, 2'b00, "R7 reload FIR");
        push(16'sd100, 0, 0, "R7 flushed FIR");
        push(16'sd0, 0, 0, "R7 flushed FIR");

        // R3: IIR step and sweep
        idle(1, 2'b01, "R6 to IIR");
        for (int i = 0; i < 40; i++) push(16'sd20000, 0, 0, "R3 step");
        for (int i = 0; i < 300; i++) push(16'(i * 4099 - 30000), 0, 0, "R3 sweep");

        // R4: Haar stage
        idle(1, 2'b10, "R6 to Haar");
        for (int i = 0; i < 400; i++) push(16'(i * 6007 + 5), 0, 0, "R4 sweep");
        push(16'h8000, 0, 0, "R4 extreme pair");
        push(16'h7fff, 0, 0, "R4 extreme pair");

        // R5: halt code drops samples
        idle(1, 2'b11, "R5 to halt");
        for (int i = 0; i < 10; i++) push(16'(i * 333), 0, 0, "R5 halted");

        // R6: mid-stream request is deferred while samples flow
        idle(1, 2'b00, "R6 to FIR");
        for (int i = 0; i < 6; i++) push(16'(i * 1111), 0, 0, "R2 pre-switch");
        push(16'sd555, 1, 2'b01, "R6 pending keeps FIR");
        for (int i = 0; i < 5; i++) push(16'(i * 2222 + 7), 0, 0, "R6 still FIR");
        idle(0, 2'b00, "R6 deferred switch");
        for (int i = 0; i < 20; i++) push(16'(i * 3001), 0, 0, "R3 after switch");

        // R8: last of several pending codes wins
        push(16'sd10, 1, 2'b00, "R8 first request");
        push(16'sd20, 1, 2'b10, "R8 second request");
        idle(0, 2'b00, "R8 switch");
        push(16'sd1234, 0, 0, "R8 Haar first silent");
        push(-16'sd4321, 0, 0, "R8 Haar pair");

        // R9: gaps between samples give no result
        idle(0, 2'b00, "R9 gap");
        idle(0, 2'b00, "R9 gap");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule